// File: doc/BRIEF.md
# Scrunching Systolic Event Priority Queue

This block is a linear, time-ordered queue of pending simulation events. Each slot holds a valid bit, a 32-bit time tag and a 26-bit payload. The payload is split into two 13-bit particle IDs. Slot 0 is the head, and its registered contents drive the dequeue port directly, so a consumer can take one event per clock. The queue does several things in the same cycle:

- it accepts one new event into the slot that keeps the valid entries sorted by time tag;
- it applies one broadcast invalidation, which may hit any number of slots;
- it moves the entries behind a vacancy toward the head.

Invalidated entries leave holes in the queue. The queue closes those holes by letting an entry advance by two slots when the two slots in front of it are both empty, and by one slot when only the next slot is empty. A hole that reaches the head gives a cycle with no valid output. This is a bubble, not a stall. When the consumer holds off, the head entry stays in place, but the entries behind it keep compacting.

Top module: `evq_scrunch`

## Requirements
- R1: After a synchronous active-high reset, every slot is empty, `deq_valid` is low and `overflow` is low.
- R2: The head slot is presented on `deq_valid`, `deq_time` and `deq_payload`. It is consumed at a clock edge where `deq_valid` and `deq_ready` are both high.
- R3: An event inserted at an edge is placed among the valid entries in ascending time-tag order. An event inserted into an empty queue is at the head after that edge.
- R4: A new event whose time tag equals that of existing entries is placed behind all of them, so equal tags leave in arrival order.
- R5: When `inv_valid` is high, every entry whose upper ID (payload bits 25:13) or lower ID (bits 12:0) equals `inv_id` is removed at that edge, however many there are. A removed entry is never dequeued.
- R6: A valid entry whose next slot toward the head is empty, and whose slot two ahead is occupied (or which sits in slot 1), advances by exactly one slot per edge.
- R7: A valid entry whose next two slots toward the head are both empty advances by two slots in one edge.
- R8: When the head slot is empty after an edge, `deq_valid` is low for that cycle even if valid entries remain further back.
- R9: While `deq_ready` is low, the head entry is held unchanged, unless an earlier-tagged insert displaces it or an invalidation removes it. Entries behind the head still compact.
- R10: An insert that finds no empty slot at or after its ordered position drops the entry with the latest time tag. The new event is dropped if it is the latest; otherwise the tail entry is dropped. The `overflow` flag is high for the cycle after that edge.
- R11: While slots 0 and 1 both hold valid entries and `deq_ready` is high, an event is delivered on every clock, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_time | input | 32 | Time tag of the inserted event |
| ins_payload | input | 26 | Payload: two 13-bit particle IDs |
| inv_valid | input | 1 | Invalidation broadcast this cycle |
| inv_id | input | 13 | Particle ID to invalidate |
| deq_ready | input | 1 | Consumer accepts the head event |
| deq_valid | output | 1 | Head slot holds a valid event |
| deq_time | output | 32 | Time tag of the head event |
| deq_payload | output | 26 | Payload of the head event |
| overflow | output | 1 | An entry was dropped at the previous edge |

## Verification
Each input pattern targets one behaviour and tells it apart from a plausible wrong one:

- **Scrambled inserts, then a drain.** This checks ordered placement and rules out plain appending.
- **Runs of equal tags with distinct payloads.** This separates stable placement from placement ahead of equals.
- **Invalidations that match on the upper ID, the lower ID, several slots at once, or nothing.** These show whether both ID fields are decoded and whether many slots can be cleared in one cycle.
- **Pairs of adjacent holes, made once while stalled and once together with a pop.** The first case shows the two-slot advance without a bubble. The second shows the bubble that a hole at the head produces.
- **A full queue fed with a latest-tag event and then an earliest-tag event.** This tells the two drop cases apart.
- **Continuous insert-and-drain, followed by a long stretch of mixed random traffic.** A small ID and tag range is used so that collisions are frequent. Every head value and bubble is then compared against the behavioural reference.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int TIME_W = 32;
    localparam int ID_W   = 13;
    localparam int PAY_W  = 2 * ID_W;

    typedef struct packed {
        logic              v;
        logic [TIME_W-1:0] t;
        logic [PAY_W-1:0]  p;
    } ev_t;

    localparam ev_t EV_NONE = '0;

    // true when either particle field of a payload names the given particle
    function automatic logic id_hit(input logic [PAY_W-1:0] p, input logic [ID_W-1:0] id);
        return (p[PAY_W-1:ID_W] == id) || (p[ID_W-1:0] == id);
    endfunction
endpackage

// File: rtl/evq_kill.sv
module evq_kill
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            pop,
    input  logic            inv_valid,
    input  logic [ID_W-1:0] inv_id,
    input  ev_t             q_i [DEPTH],
    output ev_t             k_o [DEPTH]
);
    logic [DEPTH-1:0] hit;

    // one comparator pair per slot, all evaluated in parallel
    for (genvar k = 0; k < DEPTH; k++) begin : g_match
        if (k == 0) begin : g_head
            assign hit[k] = pop || (inv_valid && id_hit(q_i[k].p, inv_id));
        end else begin : g_body
            assign hit[k] = inv_valid && id_hit(q_i[k].p, inv_id);
        end
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            k_o[k] = q_i[k];
            if (hit[k]) k_o[k].v = 1'b0;
        end
    end
endmodule

// File: rtl/evq_compact.sv
module evq_compact
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  ev_t  e_i [DEPTH],
    output ev_t  m_o [DEPTH]
);
    logic [DEPTH-1:0] v;
    logic [DEPTH+1:0] vpad;   // vpad[k] = slot k valid, zero past the tail
    logic [DEPTH:0]   vlo;    // vlo[k]  = slot k-1 valid, one at the head
    logic [DEPTH-1:0] keep, from1, from2;
    ev_t              nx1 [DEPTH];
    ev_t              nx2 [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_v
        assign v[k] = e_i[k].v;
    end
    assign vpad = {2'b00, v};
    assign vlo  = {v, 1'b1};

    // each slot chooses from itself, the next slot or the one after
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        assign keep[k]  = v[k] & vlo[k];
        assign from1[k] = vpad[k+1] & ~v[k] & vlo[k];
        assign from2[k] = vpad[k+2] & ~vpad[k+1] & ~v[k];
        if (k + 1 < DEPTH) begin : g_n1
            assign nx1[k] = e_i[k+1];
        end else begin : g_n1z
            assign nx1[k] = EV_NONE;
        end
        if (k + 2 < DEPTH) begin : g_n2
            assign nx2[k] = e_i[k+2];
        end else begin : g_n2z
            assign nx2[k] = EV_NONE;
        end
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            if (keep[k])       m_o[k] = e_i[k];
            else if (from1[k]) m_o[k] = nx1[k];
            else if (from2[k]) m_o[k] = nx2[k];
            else               m_o[k] = EV_NONE;
        end
    end

    logic [DEPTH-1:0] mv;
    for (genvar k = 0; k < DEPTH; k++) begin : g_mv
        assign mv[k] = m_o[k].v;
    end

    // R6 / R7: moving entries neither creates nor loses events
    p_move_conserves_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(mv) == $countones(v));
    // R6: a slot never takes an entry from two sources at once
    p_one_source_r6: assert property (@(posedge clk) disable iff (rst)
        ($countones(keep) + $countones(from1) + $countones(from2)) == $countones(mv));
endmodule

// File: rtl/evq_place.sv
module evq_place
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [PAY_W-1:0]  ins_payload,
    input  ev_t               m_i [DEPTH],
    output ev_t               n_o [DEPTH],
    output logic              drop
);
    logic [DEPTH-1:0] gt, tail, sel;
    logic [DEPTH:0]   later_v;
    logic [DEPTH-1:0] prev_lv;
    logic             any_gt;
    ev_t              prv [DEPTH];
    ev_t              fresh;

    assign fresh = '{v: 1'b1, t: ins_time, p: ins_payload};

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        // strictly later tag: equal tags stay ahead of the newcomer (R4)
        assign gt[k] = m_i[k].v && (m_i[k].t > ins_time);
        if (k == 0) begin : g_p0
            assign prv[k]     = EV_NONE;
            assign prev_lv[k] = 1'b1;
        end else begin : g_pk
            assign prv[k]     = m_i[k-1];
            assign prev_lv[k] = later_v[k-1];
        end
        assign tail[k] = ~later_v[k] & prev_lv[k];
    end

    always_comb begin
        later_v[DEPTH] = 1'b0;
        for (int k = DEPTH - 1; k >= 0; k--) later_v[k] = later_v[k+1] | m_i[k].v;
    end

    always_comb begin
        any_gt = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            sel[k] = gt[k] & ~any_gt;
            any_gt = any_gt | gt[k];
        end
        if (!any_gt) sel = tail;
    end

    always_comb begin
        logic in_reg, open;
        in_reg = 1'b0;
        open   = 1'b0;
        drop   = 1'b0;
        for (int k = 0; k < DEPTH; k++) n_o[k] = m_i[k];
        if (ins_valid) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (sel[k]) begin
                    n_o[k] = fresh;
                    in_reg = 1'b1;
                    open   = m_i[k].v;
                end else if (in_reg) begin
                    if (open) n_o[k] = prv[k];
                    open = open & m_i[k].v;
                end
            end
            drop = ~|sel | open;
        end
    end

    p_single_slot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/evq_scrunch.sv
module evq_scrunch
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [PAY_W-1:0]  ins_payload,
    input  logic              inv_valid,
    input  logic [ID_W-1:0]   inv_id,
    input  logic              deq_ready,
    output logic              deq_valid,
    output logic [TIME_W-1:0] deq_time,
    output logic [PAY_W-1:0]  deq_payload,
    output logic              overflow
);
    ev_t  q      [DEPTH];
    ev_t  killed [DEPTH];
    ev_t  moved  [DEPTH];
    ev_t  nxt    [DEPTH];
    logic drop;
    logic ovf_q;
    logic pop;
    logic [DEPTH-1:0] vq;

    assign deq_valid   = q[0].v;
    assign deq_time    = q[0].t;
    assign deq_payload = q[0].p;
    assign overflow    = ovf_q;
    assign pop         = q[0].v & deq_ready;

    for (genvar k = 0; k < DEPTH; k++) begin : g_vq
        assign vq[k] = q[k].v;
    end

    evq_kill #(.DEPTH(DEPTH)) u_kill (
        .pop(pop), .inv_valid(inv_valid), .inv_id(inv_id),
        .q_i(q), .k_o(killed)
    );

    evq_compact #(.DEPTH(DEPTH)) u_compact (
        .clk(clk), .rst(rst), .e_i(killed), .m_o(moved)
    );

    evq_place #(.DEPTH(DEPTH)) u_place (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_time(ins_time), .ins_payload(ins_payload),
        .m_i(moved), .n_o(nxt), .drop(drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) q[k] <= EV_NONE;
            ovf_q <= 1'b0;
        end else begin
            q     <= nxt;
            ovf_q <= drop;
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        $past(rst) |-> (!deq_valid && !overflow));
    p_empty_insert_r3: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && vq == '0) |=> (deq_valid && deq_time == $past(ins_time)));
    p_ovf_needs_insert_r10: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid) |=> !overflow);
    p_hold_head_r9: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready && !ins_valid && !inv_valid) |=>
        (deq_valid && $stable(deq_time) && $stable(deq_payload)));
    p_back_to_back_r11: assert property (@(posedge clk) disable iff (rst)
        (vq[0] && vq[1] && deq_ready && !inv_valid) |=> deq_valid);
    p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        (vq[2:0] == 3'b000 && !ins_valid) |=> !deq_valid);
endmodule

// File: tb/test_evq_scrunch.sv
`timescale 1ns/1ps
module test_evq_scrunch;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_time = '0;
    logic [25:0] ins_payload = '0;
    logic        inv_valid = 1'b0;
    logic [12:0] inv_id = '0;
    logic        deq_ready = 1'b0;
    logic        deq_valid;
    logic [31:0] deq_time;
    logic [25:0] deq_payload;
    logic        overflow;

    always #2.5 clk = ~clk;

    evq_scrunch #(.DEPTH(D)) i_evq_scrunch (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_time(ins_time), .ins_payload(ins_payload),
        .inv_valid(inv_valid), .inv_id(inv_id),
        .deq_ready(deq_ready), .deq_valid(deq_valid),
        .deq_time(deq_time), .deq_payload(deq_payload), .overflow(overflow)
    );

    // behavioural reference state
    bit          mv [D];
    logic [31:0] mt [D];
    logic [25:0] mp [D];
    bit          movf;
    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    function automatic logic [25:0] pl(input int hi, input int lo);
        return {hi[12:0], lo[12:0]};
    endfunction

    task automatic compare(input string rq);
        vectors++;
        if (deq_valid !== mv[0]) begin
            errors++;
            $display("FAIL %s deq_valid got %0b exp %0b", rq, deq_valid, mv[0]);
        end
        if (mv[0]) begin
            vectors++;
            if (deq_time !== mt[0] || deq_payload !== mp[0]) begin
                errors++;
                $display("FAIL %s head got t=%0d p=%h exp t=%0d p=%h",
                         rq, deq_time, deq_payload, mt[0], mp[0]);
            end
        end
        vectors++;
        if (overflow !== movf) begin
            errors++;
            $display("FAIL %s overflow got %0b exp %0b", rq, overflow, movf);
        end
    endtask

    task automatic model(input bit iv, input logic [31:0] it, input logic [25:0] ip,
                         input bit xv, input logic [12:0] xid, input bit rdy);
        bit          ev [D];
        bit          nv [D];
        logic [31:0] nt [D];
        logic [25:0] np [D];
        int p, h, last;
        for (int k = 0; k < D; k++) begin
            ev[k] = mv[k];
            nv[k] = 1'b0; nt[k] = '0; np[k] = '0;
        end
        if (ev[0] && rdy) ev[0] = 1'b0;                          // R2 pop
        for (int k = 0; k < D; k++)                              // R5 kill
            if (ev[k] && xv && (mp[k][25:13] == xid || mp[k][12:0] == xid)) ev[k] = 1'b0;
        for (int k = 0; k < D; k++) begin                        // R6 / R7 moves
            int s = 0;
            if (ev[k]) begin
                if (k >= 1 && !ev[k-1]) s = 1;
                if (k >= 2 && !ev[k-1] && !ev[k-2]) s = 2;
                nv[k-s] = 1'b1; nt[k-s] = mt[k]; np[k-s] = mp[k];
            end
        end
        movf = 1'b0;
        if (iv) begin                                            // R3 / R4 / R10
            p = -1;
            for (int k = 0; k < D; k++) if (nv[k] && nt[k] > it && p < 0) p = k;
            if (p < 0) begin
                last = -1;
                for (int k = 0; k < D; k++) if (nv[k]) last = k;
                p = last + 1;
            end
            if (p == D) movf = 1'b1;
            else begin
                h = -1;
                for (int k = p; k < D; k++) if (!nv[k] && h < 0) h = k;
                if (h < 0) begin h = D - 1; movf = 1'b1; end
                for (int k = h; k > p; k--) begin
                    nv[k] = nv[k-1]; nt[k] = nt[k-1]; np[k] = np[k-1];
                end
                nv[p] = 1'b1; nt[p] = it; np[p] = ip;
            end
        end
        for (int k = 0; k < D; k++) begin
            mv[k] = nv[k]; mt[k] = nt[k]; mp[k] = np[k];
        end
    endtask

    task automatic step(input bit iv, input logic [31:0] it, input logic [25:0] ip,
                        input bit xv, input logic [12:0] xid, input bit rdy, input string rq);
        @(negedge clk);
        compare(rq);
        ins_valid = iv; ins_time = it; ins_payload = ip;
        inv_valid = xv; inv_id = xid; deq_ready = rdy;
        model(iv, it, ip, xv, xid, rdy);
    endtask

    task automatic idle(input int n, input bit rdy, input string rq);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rdy, rq);
    endtask

    initial begin
        for (int k = 0; k < D; k++) begin mv[k] = 0; mt[k] = 0; mp[k] = 0; end
        movf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle(2, 0, "R1");

        // R3: scrambled tags, stalled, then drained in order (R2)
        step(1, 50, pl(1, 2), 0, 0, 0, "R3");
        step(1, 20, pl(3, 4), 0, 0, 0, "R3");
        step(1, 80, pl(5, 6), 0, 0, 0, "R3");
        step(1, 35, pl(7, 8), 0, 0, 0, "R3");
        step(1,  5, pl(9, 10), 0, 0, 0, "R3");
        idle(8, 1, "R2");

        // R4: equal tags keep arrival order
        step(1, 40, pl(11, 1), 0, 0, 0, "R4");
        step(1, 40, pl(11, 2), 0, 0, 0, "R4");
        step(1, 30, pl(11, 3), 0, 0, 0, "R4");
        step(1, 40, pl(11, 4), 0, 0, 0, "R4");
        step(1, 30, pl(11, 5), 0, 0, 0, "R4");
        idle(7, 1, "R4");

        // R5: upper-field, lower-field, multi-slot and missing matches
        for (int i = 0; i < 8; i++) step(1, 100 + i, pl(20 + (i % 3), 40 + i), 0, 0, 0, "R5");
        step(0, 0, 0, 1, 21, 0, "R5");
        step(0, 0, 0, 1, 43, 0, "R5");
        step(0, 0, 0, 1, 999, 0, "R5");
        idle(8, 1, "R5");

        // R7 / R9: adjacent holes made while stalled, head held
        for (int i = 0; i < 8; i++)
            step(1, 10 * (i + 1), pl(200 + i, (i == 2 || i == 3) ? 500 : 300 + i), 0, 0, 0, "R9");
        step(0, 0, 0, 1, 500, 0, "R7");
        idle(3, 0, "R9");
        idle(8, 1, "R7");

        // R8: holes behind the head created together with a pop
        for (int i = 0; i < 6; i++)
            step(1, 10 * (i + 1), pl(600 + i, (i == 1 || i == 2) ? 700 : 650 + i), 0, 0, 0, "R8");
        step(0, 0, 0, 1, 700, 1, "R8");
        idle(6, 1, "R8");

        // R10: full queue, latest-tag insert then earliest-tag insert
        for (int i = 0; i < D; i++) step(1, 100 + i, pl(800, i), 0, 0, 0, "R10");
        step(1, 200, pl(801, 1), 0, 0, 0, "R10");
        step(1,   5, pl(801, 2), 0, 0, 0, "R10");
        idle(D + 3, 1, "R10");

        // R11: continuous insert and drain
        for (int i = 0; i < 24; i++) step(1, 1000 + i, pl(900, i), 0, 0, 1, "R11");
        idle(4, 1, "R11");

        // R6: mixed random traffic with frequent collisions
        for (int i = 0; i < 3000; i++) begin
            bit rdy;
            rdy = ((i / 200) % 2 == 0) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            step($urandom % 2, $urandom % 64, pl($urandom % 8, $urandom % 8),
                 ($urandom % 4 == 0), $urandom % 8, rdy, "R6");
        end
        idle(D + 2, 1, "R6");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule